// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block decides, at instruction boundaries, whether to take a pending maskable interrupt. The request line is level sensitive and is registered on every rising clock edge. When the boundary strobe arrives and the registered request, the enable flag and an idle bus (no hold request) all agree, the sequencer takes the interrupt:

- It clears the enable flag and keeps the flag's previous value for the stack save.
- It runs two back-to-back acknowledge bus cycles of four T-states each.
- It holds a lock output across the junction between the two cycles.

During the second cycle it latches the interrupt type byte from the data bus. One clock after the sequence completes, it presents the vector-table address, which is the type times four, together with a one-clock valid pulse.

The surrounding execution unit is reduced to a few strobes:

- **Boundary:** a strobe that marks the last clock of an instruction or of one element of a block operation.
- **Enable control:** set and clear strobes for the enable flag.
- **Return from interrupt:** a strobe that carries the restored enable bit.

A busy output tells the execution unit to stall while the sequence runs. A local bus hold request is granted only while the sequencer is idle.

Top module: `intack_seq`

## Requirements
- R1: The request input is registered on each rising edge. Only the registered value is used for the decision, so a request must already be high one clock before the boundary clock. A request that first rises in the boundary clock itself is not taken on that boundary.
- R2: An interrupt is taken at the rising edge that ends a clock in which all of the following hold: the block is idle, `instrEnd`=1, the registered request is 1, `ieFlag`=1 and `holdReq`=0. In every other case `busy` stays 0.
- R3: A taken interrupt runs exactly two consecutive acknowledge cycles of four clocks each (T1..T4), with nothing between them, so `busy` is 1 for 8 clocks. `inta` is 1 in T2 and T3 of each cycle, which gives the pattern 0,1,1,0,0,1,1,0 over the 8 clocks.
- R4: `busLock` is 1 from T2 of the first acknowledge cycle through T1 of the second. It is 1 for 4 clocks and falls at T2 of the second cycle, giving the pattern 0,1,1,1,1,0,0,0.
- R5: `holdGrant` equals `holdReq` while idle. It is 0 throughout the acknowledge sequence and first follows a pending request in the clock after T4 of the second cycle.
- R6: `dataIn` is latched at the end of T3 of the second cycle. `vecAddr` is {type, 2'b00}, that is, type times 4, 10 bits wide.
- R7: `vecValid` is a single-clock pulse in the clock after T4 of the second cycle.
- R8: Taking an interrupt clears `ieFlag`, and `savedIe` takes the value `ieFlag` had just before the take. The take overrides any flag strobe in the same clock.
- R9: `iretStrobe` loads `ieFlag` from `iretIe`. A request that is still high is then taken again at the next boundary.
- R10: `ieFlag` resets to 0. `ieSet` sets it and `ieClr` clears it. The priority is take > `iretStrobe` > `ieClr` > `ieSet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| intReq | input | 1 | Level-sensitive maskable interrupt request |
| instrEnd | input | 1 | Marks the last clock of an instruction or block element |
| holdReq | input | 1 | Local bus hold request |
| ieSet | input | 1 | Set the enable flag |
| ieClr | input | 1 | Clear the enable flag |
| iretStrobe | input | 1 | Return from interrupt: restore enable flag |
| iretIe | input | 1 | Enable bit restored by the return |
| dataIn | input | 8 | Data bus carrying the type byte |
| busy | output | 1 | Acknowledge sequence in progress; stalls execution |
| inta | output | 1 | Acknowledge strobe (T2 and T3 of each cycle) |
| busLock | output | 1 | Bus lock across the two acknowledge cycles |
| holdGrant | output | 1 | Hold request granted |
| ieFlag | output | 1 | Current interrupt enable flag |
| savedIe | output | 1 | Enable flag value before the last take |
| vecAddr | output | 10 | Vector table address (type x 4) |
| vecValid | output | 1 | One-clock pulse: vecAddr is valid |

## Verification
The hardest cases to reach involve the one-clock sampling lag. The first is a request that rises in the same clock as the boundary strobe. The second is a request that stays high through a service and must be taken again only once a return strobe has restored the flag. The stimulus drives the request and the boundary together in one clock and checks that `busy` stays low. It then leaves the request high after a full sequence, offers a boundary with the flag cleared, restores the flag through the return strobe and offers a second boundary. A hold request is raised at T1 of the first cycle and kept up throughout, so the grant's first rise lands exactly one clock after the second cycle ends.

// File: rtl/intack_pkg.sv
package intack_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_A1_T1 = 4'd1,
    ST_A1_T2 = 4'd2,
    ST_A1_T3 = 4'd3,
    ST_A1_T4 = 4'd4,
    ST_A2_T1 = 4'd5,
    ST_A2_T2 = 4'd6,
    ST_A2_T3 = 4'd7,
    ST_A2_T4 = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic take;       // interrupt accepted this clock
    logic latchType;  // end of T3 in second acknowledge cycle
    logic seqDone;    // end of T4 in second acknowledge cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrEnd,
  input  logic         holdReq,
  input  logic         reqSync,
  input  logic         ieFlag,
  output ctrl_strobe_t strb,
  output logic         busy,
  output logic         inta,
  output logic         busLock,
  output logic         holdGrant
);

  seq_state_e stateQ, stateNext;
  logic       idle;
  logic       takeNow;

  assign idle    = (stateQ == ST_IDLE);
  assign takeNow = idle && instrEnd && reqSync && ieFlag && !holdReq;

  always_comb begin
    if (idle)
      stateNext = takeNow ? ST_A1_T1 : ST_IDLE;
    else if (stateQ == ST_A2_T4)
      stateNext = ST_IDLE;
    else
      stateNext = seq_state_e'(stateQ + 4'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  assign strb.take      = takeNow;
  assign strb.latchType = (stateQ == ST_A2_T3);
  assign strb.seqDone   = (stateQ == ST_A2_T4);

  assign busy      = !idle;
  assign inta      = (stateQ == ST_A1_T2) || (stateQ == ST_A1_T3) ||
                     (stateQ == ST_A2_T2) || (stateQ == ST_A2_T3);
  assign busLock   = (stateQ == ST_A1_T2) || (stateQ == ST_A1_T3) ||
                     (stateQ == ST_A1_T4) || (stateQ == ST_A2_T1);
  assign holdGrant = holdReq && idle;

  // R3: second acknowledge cycle directly follows the first
  a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_A1_T4) |=> (stateQ == ST_A2_T1));

  // R4: lock rises together with the first acknowledge strobe
  a_r4_lock_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLock) |-> (inta && $past(stateQ == ST_A1_T1)));

  // R2: a take always starts the sequence
  a_r2_take_starts: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (stateQ == ST_A1_T1));

endmodule

// File: rtl/intack_dp.sv
module intack_dp
  import intack_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2,
  localparam int VEC_W    = TYPE_W + VEC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              intReq,
  input  logic              ieSet,
  input  logic              ieClr,
  input  logic              iretStrobe,
  input  logic              iretIe,
  input  logic [TYPE_W-1:0] dataIn,
  output logic              reqSync,
  output logic              ieFlag,
  output logic              savedIe,
  output logic [VEC_W-1:0]  vecAddr,
  output logic              vecValid
);

  logic [TYPE_W-1:0] typeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSync  <= 1'b0;
      ieFlag   <= 1'b0;
      savedIe  <= 1'b0;
      typeQ    <= '0;
      vecValid <= 1'b0;
    end else begin
      reqSync  <= intReq;
      vecValid <= strb.seqDone;
      if (strb.latchType) typeQ <= dataIn;
      if (strb.take)      savedIe <= ieFlag;
      if (strb.take)           ieFlag <= 1'b0;
      else if (iretStrobe)     ieFlag <= iretIe;
      else if (ieClr)          ieFlag <= 1'b0;
      else if (ieSet)          ieFlag <= 1'b1;
    end
  end

  assign vecAddr = {typeQ, {VEC_SHIFT{1'b0}}};

  // R8: enable flag is cleared and the prior value kept after a take
  a_r8_ie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (!ieFlag && savedIe));

  // R7: valid marker lasts a single clock
  a_r7_vec_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2,
  localparam int VEC_W    = TYPE_W + VEC_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic              instrEnd,
  input  logic              holdReq,
  input  logic              ieSet,
  input  logic              ieClr,
  input  logic              iretStrobe,
  input  logic              iretIe,
  input  logic [TYPE_W-1:0] dataIn,
  output logic              busy,
  output logic              inta,
  output logic              busLock,
  output logic              holdGrant,
  output logic              ieFlag,
  output logic              savedIe,
  output logic [VEC_W-1:0]  vecAddr,
  output logic              vecValid
);

  ctrl_strobe_t strb;
  logic         reqSync;

  intack_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrEnd  (instrEnd),
    .holdReq   (holdReq),
    .reqSync   (reqSync),
    .ieFlag    (ieFlag),
    .strb      (strb),
    .busy      (busy),
    .inta      (inta),
    .busLock   (busLock),
    .holdGrant (holdGrant)
  );

  intack_dp #(.TYPE_W(TYPE_W), .VEC_SHIFT(VEC_SHIFT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .intReq     (intReq),
    .ieSet      (ieSet),
    .ieClr      (ieClr),
    .iretStrobe (iretStrobe),
    .iretIe     (iretIe),
    .dataIn     (dataIn),
    .reqSync    (reqSync),
    .ieFlag     (ieFlag),
    .savedIe    (savedIe),
    .vecAddr    (vecAddr),
    .vecValid   (vecValid)
  );

  // R5: bus never granted while locked
  a_r5_no_grant_locked: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> !holdGrant);

  // R7: valid vector only once the sequence has ended
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> !busy);

endmodule

// File: tb/intack_seq_tb_top.sv
module intack_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intReq = 0, instrEnd = 0, holdReq = 0;
  logic       ieSet = 0, ieClr = 0, iretStrobe = 0, iretIe = 0;
  logic [7:0] dataIn = '0;
  logic       busy, inta, busLock, holdGrant, ieFlag, savedIe, vecValid;
  logic [9:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  intack_seq dut_i (
    .clk(clk), .rstN(rstN), .intReq(intReq), .instrEnd(instrEnd),
    .holdReq(holdReq), .ieSet(ieSet), .ieClr(ieClr),
    .iretStrobe(iretStrobe), .iretIe(iretIe), .dataIn(dataIn),
    .busy(busy), .inta(inta), .busLock(busLock), .holdGrant(holdGrant),
    .ieFlag(ieFlag), .savedIe(savedIe), .vecAddr(vecAddr), .vecValid(vecValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fields: {type[7:0], ieOn, reqOn}
  localparam logic [9:0] VEC_TAB [8] = '{
    {8'h21, 1'b1, 1'b1}, {8'h00, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b1},
    {8'h40, 1'b0, 1'b1}, {8'h13, 1'b1, 1'b0}, {8'hA5, 1'b1, 1'b1},
    {8'h7E, 1'b0, 1'b0}, {8'h80, 1'b1, 1'b1}
  };

  // runs the 8 acknowledge clocks starting at c0 (sampled at negedge)
  task automatic walkSequence(input logic [7:0] typ);
    logic [7:0] lockPat, intaPat, grantPat, busyPat;
    lockPat = '0; intaPat = '0; grantPat = '0; busyPat = '0;
    holdReq = 1'b1;
    for (int i = 0; i < 8; i++) begin
      lockPat[i]  = busLock;
      intaPat[i]  = inta;
      grantPat[i] = holdGrant;
      busyPat[i]  = busy;
      if (i == 6) dataIn = typ;
      @(negedge clk);
      if (i == 6) dataIn = ~typ;  // changes after the T3 latch edge
    end
    check("R3 busy pattern", busyPat, 8'hFF);
    check("R3 inta pattern", intaPat, 8'b0110_0110);
    check("R4 lock pattern", lockPat, 8'b0001_1110);
    check("R5 no grant in sequence", grantPat, 8'h00);
    check("R5 grant after sequence", holdGrant, 1'b1);
    check("R7 valid pulse", vecValid, 1'b1);
    check("R6 vector address", vecAddr, {22'd0, typ, 2'b00});
    check("R8 ie cleared", ieFlag, 1'b0);
    check("R8 saved ie", savedIe, 1'b1);
    holdReq = 1'b0;
    @(negedge clk);
    check("R7 pulse ends", vecValid, 1'b0);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset ie", ieFlag, 1'b0);
    check("R3 reset busy", busy, 1'b0);
    check("R7 reset valid", vecValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R2 take condition and full sequence
    for (int v = 0; v < 8; v++) begin
      logic [7:0] typ;
      logic ieOn, reqOn;
      {typ, ieOn, reqOn} = VEC_TAB[v];
      ieSet = ieOn; ieClr = !ieOn; intReq = reqOn; dataIn = 8'h5A;
      @(negedge clk);
      ieSet = 0; ieClr = 0; instrEnd = 1'b1;
      @(negedge clk);
      instrEnd = 1'b0;
      check("R2 take decision", busy, ieOn & reqOn);
      if (ieOn & reqOn) walkSequence(typ);
      else check("R10 flag strobes", ieFlag, ieOn);
      intReq = 1'b0;
      @(negedge clk);
    end

    // R1: request rising in the boundary clock is not taken
    ieSet = 1; @(negedge clk); ieSet = 0;
    intReq = 1'b1; instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
    check("R1 late request ignored", busy, 1'b0);
    // request now registered: taken on next boundary
    instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
    check("R1 registered request taken", busy, 1'b1);
    walkSequence(8'h3C);

    // R9: request still high, flag clear -> not taken; restore then retaken
    instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
    check("R9 masked while ie clear", busy, 1'b0);
    iretStrobe = 1'b1; iretIe = 1'b1;
    @(negedge clk);
    iretStrobe = 1'b0;
    check("R9 iret restores ie", ieFlag, 1'b1);
    instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
    check("R9 held request retaken", busy, 1'b1);
    walkSequence(8'hC3);
    intReq = 1'b0;

    // R10: priority iret over set
    iretStrobe = 1'b1; iretIe = 1'b0; ieSet = 1'b1;
    @(negedge clk);
    iretStrobe = 1'b0; ieSet = 1'b0;
    check("R10 iret beats set", ieFlag, 1'b0);
    ieClr = 1'b1; ieSet = 1'b1;
    @(negedge clk);
    ieClr = 1'b0; ieSet = 1'b0;
    check("R10 clear beats set", ieFlag, 1'b0);

    // R8: take overrides a same-clock set strobe
    ieSet = 1; intReq = 1;
    @(negedge clk);
    instrEnd = 1'b1; ieSet = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0; ieSet = 1'b0;
    check("R8 take overrides set", ieFlag, 1'b0);
    walkSequence(8'h01);
    intReq = 1'b0;

    // R5/R2: hold request while idle is granted and blocks a take
    ieSet = 1; intReq = 1;
    @(negedge clk);
    ieSet = 0; holdReq = 1'b1; instrEnd = 1'b1;
    #1;
    check("R5 idle grant", holdGrant, 1'b1);
    @(negedge clk);
    instrEnd = 1'b0;
    check("R2 hold blocks take", busy, 1'b0);
    holdReq = 1'b0; intReq = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule